// File: doc/BRIEF.md
# Trap and Exception-Return PC Unit

This block produces the next program counter for a simple 32-bit fetch front end. Each cycle it takes the current fetch address, a two-bit instruction class from decode and the 26-bit name field of a jump-format instruction. On a clock edge where the advance enable is high, it registers a new PC: the sequential successor, a trap target, or the saved return point.

A trap jumps to an absolute address. That address is the name field padded with zeros up to 32 bits. The same edge writes PC + 8 into an interrupt address register, so that the return skips the branch delay slot. An exception return loads the PC from that register and leaves the register as it was. A no-op only advances the PC. The register contents are visible at an output, so later stages can read the saved return point.

Class encoding on `instr_class`: 2'b00 sequential, 2'b01 trap, 2'b10 return from exception, 2'b11 no-op.

Top module: `trap_pc_unit`

## Requirements
- R1: After a rising edge with `rst_n` low (synchronous, active low), `pc_next` is 0x00000000 and `iar_value` is 0x00000000.
- R2: For class 2'b00 (sequential) with `advance` high, the next edge sets `pc_next` to `pc_cur` + 4, wrapping modulo 2^32.
- R3: For class 2'b01 (trap) with `advance` high, the next edge sets `pc_next` to `trap_name` zero-extended from bits [25:0] to 32 bits.
- R4: For class 2'b01 (trap) with `advance` high, the same edge sets `iar_value` to `pc_cur` + 8, wrapping modulo 2^32.
- R5: For class 2'b10 (return from exception) with `advance` high, the next edge sets `pc_next` to the `iar_value` held before that edge.
- R6: `iar_value` changes only on an advancing trap edge; sequential, return-from-exception and no-op edges leave it unchanged.
- R7: For class 2'b11 (no-op) with `advance` high, the next edge sets `pc_next` to `pc_cur` + 4 and leaves `iar_value` unchanged.
- R8: With `advance` low, an edge with `rst_n` high leaves both `pc_next` and `iar_value` unchanged, whatever the class.
- R9: `trap_name` has no effect on either output for any class other than trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| advance | input | 1 | Edge updates the registers only when high |
| instr_class | input | 2 | Decoded class: 00 seq, 01 trap, 10 return, 11 no-op |
| pc_cur | input | 32 | Address of the instruction being retired this cycle |
| trap_name | input | 26 | Name field of the jump-format instruction |
| pc_next | output | 32 | Registered next program counter |
| iar_value | output | 32 | Interrupt address register contents |

## Verification
The assertions assume that `advance`, `instr_class`, `pc_cur` and `trap_name` are known and stable at every rising edge while `rst_n` is high. They also assume that the value of `iar_value` seen at an edge is the one the previous edge left. The bench changes inputs only on falling edges and holds `rst_n` low across the first edges. This gives every property a defined past before it is checked. The bench mostly feeds `pc_next` back as `pc_cur`, and also injects arbitrary addresses near the 32-bit wrap point. This tests the arithmetic at the top of the address space as well as along a realistic program flow.

// File: rtl/trap_pc_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the instruction class encoding for the PC unit.
// Assumes a byte-addressed machine with fixed-size instructions.
package trap_pc_pkg;

    localparam int unsigned ADDR_W      = 32; // program counter width
    localparam int unsigned NAME_W      = 26; // jump-format name field width
    localparam int unsigned INSTR_BYTES = 4;  // size of one instruction
    localparam int unsigned DELAY_SLOTS = 1;  // slots skipped on return

    // Decoded class of the instruction being retired.
    typedef enum logic [1:0] {
        CLS_SEQ  = 2'b00,
        CLS_TRAP = 2'b01,
        CLS_RFE  = 2'b10,
        CLS_NOP  = 2'b11
    } instr_cls_e;

    // Source the next-PC mux picks from.
    typedef enum logic [1:0] {
        SRC_SEQ  = 2'b00,
        SRC_TRAP = 2'b01,
        SRC_IAR  = 2'b10
    } pc_src_e;

endpackage

// File: rtl/trap_pc_addr_calc.sv
`timescale 1ns/1ps
// Module: trap_pc_addr_calc
// Computes the candidate addresses from the current PC and name field:
// the sequential successor, the return point past the delay slot(s), and
// the zero-extended trap target. Pure combinational logic.
// Assumes AW > NW so that zero extension is meaningful.
module trap_pc_addr_calc #(
    parameter int unsigned AW     = 32,
    parameter int unsigned NW     = 26,
    parameter int unsigned STEP   = 4,
    parameter int unsigned SLOTS  = 1
) (
    input  logic [AW-1:0] pc_i,
    input  logic [NW-1:0] name_i,
    output logic [AW-1:0] seq_pc_o,
    output logic [AW-1:0] ret_pc_o,
    output logic [AW-1:0] trap_pc_o
);

    localparam int unsigned RET_OFS = STEP * (SLOTS + 1);
    localparam int unsigned PAD_W   = AW - NW;

    // Sequential successor: one instruction forward, wrapping at 2^AW.
    always_comb begin
        seq_pc_o = pc_i + AW'(STEP);
    end

    // Return point: skip the current instruction and its delay slot(s).
    always_comb begin
        ret_pc_o = pc_i + AW'(RET_OFS);
    end

    // Trap target: the name field with zeros above it.
    always_comb begin
        trap_pc_o = {{PAD_W{1'b0}}, name_i};
    end

endmodule

// File: rtl/trap_pc_iar.sv
`timescale 1ns/1ps
// Module: trap_pc_iar
// Interrupt address register. Loads the return point on an advancing
// trap and holds otherwise. Synchronous active-low reset clears it.
// Assumes the write enable is already qualified by the advance input.
module trap_pc_iar #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_val_i,
    output logic [AW-1:0] iar_o
);

    logic [AW-1:0] iar_q;

    // Storage: clear on reset, capture the return point on a trap write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iar_q <= '0;
        end else if (wr_en_i) begin
            iar_q <= wr_val_i;
        end
    end

    assign iar_o = iar_q;

    // A write lands exactly the value offered on the previous edge.
    assert_iar_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> iar_q == $past(wr_val_i));

    // Without a write the register keeps its value.
    assert_iar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(iar_q));

endmodule

// File: rtl/trap_pc_next_sel.sv
`timescale 1ns/1ps
// Module: trap_pc_next_sel
// Decodes the instruction class into a mux select and an IAR write
// strobe, then picks the next PC. Combinational only.
// Assumes class codes from trap_pc_pkg; no-op follows the sequential path.
module trap_pc_next_sel
    import trap_pc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          advance_i,
    input  logic [1:0]    cls_i,
    input  logic [AW-1:0] seq_pc_i,
    input  logic [AW-1:0] trap_pc_i,
    input  logic [AW-1:0] iar_i,
    output logic [AW-1:0] next_pc_o,
    output logic          iar_wr_o
);

    instr_cls_e cls;
    pc_src_e    src;

    // Class decode: map the incoming code onto the typed enum.
    always_comb begin
        cls = instr_cls_e'(cls_i);
    end

    // Source select: which candidate becomes the next PC.
    always_comb begin
        unique case (cls)
            CLS_TRAP: src = SRC_TRAP;
            CLS_RFE:  src = SRC_IAR;
            default:  src = SRC_SEQ;
        endcase
    end

    // Next-PC mux over the three candidates.
    always_comb begin
        unique case (src)
            SRC_TRAP: next_pc_o = trap_pc_i;
            SRC_IAR:  next_pc_o = iar_i;
            default:  next_pc_o = seq_pc_i;
        endcase
    end

    // IAR write strobe: only a trap on an advancing cycle saves a return.
    always_comb begin
        iar_wr_o = advance_i && (cls == CLS_TRAP);
    end

endmodule

// File: rtl/trap_pc_unit.sv
`timescale 1ns/1ps
// Module: trap_pc_unit (top)
// Next-PC register for a 32-bit front end with software trap and
// exception return. One instruction is retired per advancing cycle.
// Assumes decode supplies a valid class and that pc_cur is the address
// of the retiring instruction. Reset is synchronous and active low.
module trap_pc_unit
    import trap_pc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic [1:0]          instr_class,
    input  logic [ADDR_W-1:0]   pc_cur,
    input  logic [NAME_W-1:0]   trap_name,
    output logic [ADDR_W-1:0]   pc_next,
    output logic [ADDR_W-1:0]   iar_value
);

    localparam int unsigned PAD_W = ADDR_W - NAME_W;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] ret_pc;
    logic [ADDR_W-1:0] trap_pc;
    logic [ADDR_W-1:0] sel_pc;
    logic [ADDR_W-1:0] iar_q;
    logic              iar_wr;
    logic [ADDR_W-1:0] pc_q;

    trap_pc_addr_calc #(
        .AW    (ADDR_W),
        .NW    (NAME_W),
        .STEP  (INSTR_BYTES),
        .SLOTS (DELAY_SLOTS)
    ) addr_calc_i (
        .pc_i      (pc_cur),
        .name_i    (trap_name),
        .seq_pc_o  (seq_pc),
        .ret_pc_o  (ret_pc),
        .trap_pc_o (trap_pc)
    );

    trap_pc_next_sel #(
        .AW (ADDR_W)
    ) next_sel_i (
        .advance_i (advance),
        .cls_i     (instr_class),
        .seq_pc_i  (seq_pc),
        .trap_pc_i (trap_pc),
        .iar_i     (iar_q),
        .next_pc_o (sel_pc),
        .iar_wr_o  (iar_wr)
    );

    trap_pc_iar #(
        .AW (ADDR_W)
    ) iar_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (iar_wr),
        .wr_val_i (ret_pc),
        .iar_o    (iar_q)
    );

    // PC register: clear on reset, take the selected address when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (advance) begin
            pc_q <= sel_pc;
        end
    end

    assign pc_next   = pc_q;
    assign iar_value = iar_q;

    // Reset leaves both registers at zero on the following cycle.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0) && (iar_q == '0));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && instr_class == CLS_SEQ) |=>
            pc_q == $past(pc_cur) + ADDR_W'(INSTR_BYTES));

    assert_trap_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && instr_class == CLS_TRAP) |=>
            pc_q == {{PAD_W{1'b0}}, $past(trap_name)});

    assert_trap_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && instr_class == CLS_TRAP) |=>
            iar_q == $past(pc_cur) + ADDR_W'(INSTR_BYTES * (DELAY_SLOTS + 1)));

    assert_rfe_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && instr_class == CLS_RFE) |=> pc_q == $past(iar_q));

    assert_iar_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class != CLS_TRAP) |=> $stable(iar_q));

    assert_nop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && instr_class == CLS_NOP) |=>
            pc_q == $past(pc_cur) + ADDR_W'(INSTR_BYTES));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pc_q) && $stable(iar_q));

endmodule

// File: tb/trap_pc_unit_tb_top.sv
`timescale 1ns/1ps
module trap_pc_unit_tb_top;

    logic        clk;
    logic        rst_n;
    logic        advance;
    logic [1:0]  instr_class;
    logic [31:0] pc_cur;
    logic [25:0] trap_name;
    logic [31:0] pc_next;
    logic [31:0] iar_value;

    int checks;
    int failures;
    bit done;

    // Behavioural reference state.
    logic [31:0] m_pc;
    logic [31:0] m_iar;

    trap_pc_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .instr_class (instr_class),
        .pc_cur      (pc_cur),
        .trap_name   (trap_name),
        .pc_next     (pc_next),
        .iar_value   (iar_value)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, compare at the next falling edge.
    task automatic step(input logic rn, input logic en, input logic [1:0] cls,
                        input logic [31:0] pc, input logic [25:0] nm, input string tag);
        rst_n       = rn;
        advance     = en;
        instr_class = cls;
        pc_cur      = pc;
        trap_name   = nm;
        if (!rn) begin
            m_pc  = 32'h0;
            m_iar = 32'h0;
        end else if (en) begin
            case (cls)
                2'b00: m_pc = pc + 32'd4;
                2'b01: begin m_pc = {6'b0, nm}; m_iar = pc + 32'd8; end
                2'b10: m_pc = m_iar;
                default: m_pc = pc + 32'd4;
            endcase
        end
        @(negedge clk);
        check(tag, "pc_next", pc_next, m_pc);
        check(tag, "iar_value", iar_value, m_iar);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        checks = 0; failures = 0; done = 1'b0;
        m_pc = '0; m_iar = '0;
        rst_n = 1'b0; advance = 1'b0; instr_class = 2'b00;
        pc_cur = '0; trap_name = '0;
        @(negedge clk);
        // R1: reset state
        step(1'b0, 1'b1, 2'b01, 32'h1234_5678, 26'h3AB_CDEF, "R1");
        step(1'b0, 1'b0, 2'b00, 32'h0, 26'h0, "R1");
        // R2: sequential, fed back, and at the wrap point
        step(1'b1, 1'b1, 2'b00, 32'h0000_0100, 26'h0, "R2");
        step(1'b1, 1'b1, 2'b00, pc_next, 26'h0, "R2");
        step(1'b1, 1'b1, 2'b00, 32'hFFFF_FFFC, 26'h0, "R2");
        // R3/R4: trap with all-ones name, return point wraps past zero
        step(1'b1, 1'b1, 2'b01, 32'hFFFF_FFFC, 26'h3FF_FFFF, "R3");
        step(1'b1, 1'b1, 2'b01, 32'h0000_2000, 26'h000_0000, "R4");
        // R6/R7: sequential and no-op keep IAR
        step(1'b1, 1'b1, 2'b00, pc_next, 26'h155_5555, "R6");
        step(1'b1, 1'b1, 2'b11, pc_next, 26'h2AA_AAAA, "R7");
        // R5: return restores 0x2008; IAR kept (R6)
        step(1'b1, 1'b1, 2'b10, 32'hDEAD_BEE0, 26'h3FF_FFFF, "R5");
        step(1'b1, 1'b1, 2'b10, pc_next, 26'h0, "R6");
        // R8: stalled edges with every class
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 2'(k), 32'hCAFE_0000 + 32'(k), 26'h123_4567, "R8");
        // R9: junk name on non-trap classes
        step(1'b1, 1'b1, 2'b00, 32'h0000_4000, 26'h3FF_FFFF, "R9");
        step(1'b1, 1'b1, 2'b11, pc_next, 26'h1F0_F0F0, "R9");
        step(1'b1, 1'b1, 2'b10, pc_next, 26'h0AB_CDEF, "R9");
        // Mixed program flow, mostly fed back
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [31:0] p;
            logic [1:0]  c;
            string t;
            r = $urandom;
            c = r[1:0];
            p = (r[4:2] == 3'd0) ? $urandom : pc_next;
            t = (c == 2'b00) ? "R2" : (c == 2'b01) ? "R4" : (c == 2'b10) ? "R5" : "R7";
            if (r[7:5] == 3'd0) t = "R8";
            step(1'b1, r[7:5] != 3'd0, c, p, 26'($urandom), t);
        end
        // R1: reset mid-run
        step(1'b0, 1'b1, 2'b01, 32'h0000_0040, 26'h000_0100, "R1");
        step(1'b1, 1'b1, 2'b00, pc_next, 26'h0, "R2");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule